// File: doc/BRIEF.md
# Read-Priority Store Buffer

This block sits between a write-through cache and the next memory level. Stores from the processor go into a four-entry queue, and the processor waits only when every slot is taken. Stored words leave for memory later, oldest first, at one per cycle while the memory port is free.

The block has one memory port. A read miss from the cache always takes that port before any pending store. Before a read goes out, its address is compared with every occupied slot. If any slot matches, the data of the most recently queued matching store goes back to the cache in the same cycle and memory sees no read. This keeps reads consistent with stores that have not yet reached memory.

A separate empty flag lets a fence or flush wait until every queued store has been written out.

Top module: `store_drain_buffer`

## Requirements
- R1: After reset the buffer is empty: `bufEmpty`=1, `wrStall`=0, and `memValid`=0 while no read is requested.
- R2: A write with `wrValid`=1 is accepted in the same cycle unless four entries are held. `wrStall` is 1 exactly when four entries are held. A write offered while `wrStall`=1 is dropped and never reaches memory.
- R3: Stores reach memory in the order they were accepted. A store is presented with `memValid`=1, `memWrite`=1, and the address and data of the oldest entry. One entry leaves per cycle in which `memReady`=1 and the port is not taken by a read.
- R4: While `memReady`=0 no entry leaves, and the oldest store stays presented on the port unchanged.
- R5: A read that matches no entry takes the port: `memValid`=1, `memWrite`=0, `memAddr`=`rdAddr`. `rdDone` follows `memReady` and `rdData` carries `memRdata`. No store leaves in that cycle.
- R6: A read whose address equals one or more held entries completes in the same cycle (`rdDone`=1) with the data of the most recently accepted match, and no memory read is issued.
- R7: Two writes to the same address are held as two entries and both reach memory, in order.
- R8: The address compare for a read uses only the entries held at the start of the cycle. A write accepted in the same cycle does not satisfy a read.
- R9: `bufEmpty` is 1 exactly when no entry is held.
- R10: When a read is served from the buffer, the port stays free for a store, so a store may leave in the same cycle, including the very entry that served the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Store request from the cache |
| wrAddr | input | 32 | Store word address |
| wrData | input | 32 | Store data |
| wrStall | output | 1 | Buffer full; the store is not taken |
| rdValid | input | 1 | Read miss request from the cache |
| rdAddr | input | 32 | Read word address |
| rdDone | output | 1 | Read completes this cycle |
| rdData | output | 32 | Read result, valid with rdDone |
| memValid | output | 1 | Memory port request |
| memWrite | output | 1 | 1 for a store, 0 for a read |
| memAddr | output | 32 | Memory word address |
| memWdata | output | 32 | Store data to memory |
| memReady | input | 1 | Memory accepts the request this cycle |
| memRdata | input | 32 | Memory read data, valid with memReady on a read |
| bufEmpty | output | 1 | No store is held |

## Verification
Two things can happen in the same cycle: a read being answered from a slot, and the drain of that same slot or of another one. The sweep uses a small pool of word addresses, so reads often hit held entries while `memReady` is high and the queue is non-empty. The bench keeps its own queue model. Each cycle it computes the expected hit data, the expected port owner and the expected dequeue, and compares them with the ports before the next edge. The same stream also provokes a write arriving in the cycle a read checks the same address, and full-queue stalls in the same cycle as a drain.

// File: rtl/store_buf_pkg.sv
package store_buf_pkg;
  // Strobes from control to datapath for one cycle
  typedef struct packed {
    logic push;     // append incoming store at tail
    logic pop;      // retire head entry to memory
    logic rdToMem;  // memory port carries a read this cycle
  } bufStrobes_t;
endpackage

// File: rtl/store_buf_datapath.sv
module store_buf_datapath
  import store_buf_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  bufStrobes_t       strb,
  input  logic [AW-1:0]     wrAddr,
  input  logic [DW-1:0]     wrData,
  input  logic [AW-1:0]     rdAddr,
  input  logic [DW-1:0]     memRdata,
  output logic              full,
  output logic              empty,
  output logic              rdHit,
  output logic [DW-1:0]     rdData,
  output logic [AW-1:0]     memAddr,
  output logic [DW-1:0]     memWdata
);
  localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [AW-1:0]   addrQ [DEPTH];
  logic [DW-1:0]   dataQ [DEPTH];
  logic [DEPTH-1:0] vld;
  logic [PTRW-1:0] headPtr, tailPtr;
  logic [CNTW-1:0] count;
  logic [DEPTH-1:0] matchVec;
  logic [DW-1:0]   hitData;

  assign full  = (count == CNTW'(DEPTH));
  assign empty = (count == '0);

  // Per-slot address compare against the incoming read
  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign matchVec[i] = vld[i] && (addrQ[i] == rdAddr);
  end

  // Walk from oldest to youngest; the last match seen wins
  always_comb begin
    rdHit   = 1'b0;
    hitData = '0;
    for (int k = 0; k < DEPTH; k++) begin
      logic [PTRW-1:0] slot;
      slot = headPtr + PTRW'(k);
      if (matchVec[slot]) begin
        rdHit   = 1'b1;
        hitData = dataQ[slot];
      end
    end
  end

  assign rdData   = rdHit ? hitData : memRdata;
  assign memAddr  = strb.rdToMem ? rdAddr : addrQ[headPtr];
  assign memWdata = dataQ[headPtr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vld     <= '0;
      headPtr <= '0;
      tailPtr <= '0;
      count   <= '0;
    end else begin
      if (strb.pop) begin
        vld[headPtr] <= 1'b0;
        headPtr      <= headPtr + 1'b1;
      end
      if (strb.push) begin
        vld[tailPtr] <= 1'b1;
        tailPtr      <= tailPtr + 1'b1;
      end
      count <= count + CNTW'(strb.push) - CNTW'(strb.pop);
    end
  end

  always_ff @(posedge clk) begin
    if (strb.push) begin
      addrQ[tailPtr] <= wrAddr;
      dataQ[tailPtr] <= wrData;
    end
  end

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |-> !full);

  // R3
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.pop |-> !empty);

  // R9
  valid_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(vld) == int'(count));

  // R7
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.push && !strb.pop) |=> (count == $past(count) + 1'b1));

  // R4
  head_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.pop && !empty && !strb.push) |=> $stable(headPtr) && $stable(count));
endmodule

// File: rtl/store_buf_ctrl.sv
module store_buf_ctrl
  import store_buf_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrValid,
  input  logic        rdValid,
  input  logic        memReady,
  input  logic        full,
  input  logic        empty,
  input  logic        rdHit,
  output bufStrobes_t strb,
  output logic        wrStall,
  output logic        memValid,
  output logic        memWrite,
  output logic        rdDone
);
  // Reads that miss the buffer own the port; otherwise the head drains
  always_comb begin
    strb.rdToMem = rdValid && !rdHit;
    strb.push    = wrValid && !full;
    strb.pop     = !strb.rdToMem && !empty && memReady;
  end

  assign wrStall  = full;
  assign memValid = strb.rdToMem || !empty;
  assign memWrite = !strb.rdToMem;
  assign rdDone   = rdValid && (rdHit || memReady);

  // R5
  read_priority_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && !rdHit) |-> (memValid && !memWrite && !strb.pop));

  // R6
  hit_no_memread_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && rdHit) |-> (rdDone && !(memValid && !memWrite)));

  // R3
  drain_when_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && memWrite && memReady) |-> strb.pop);

  // R1
  idle_port_chk: assert property (@(posedge clk) disable iff (!rstN)
    (empty && !rdValid) |-> !memValid);
endmodule

// File: rtl/store_drain_buffer.sv
module store_drain_buffer
  import store_buf_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrValid,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  output logic          wrStall,
  input  logic          rdValid,
  input  logic [AW-1:0] rdAddr,
  output logic          rdDone,
  output logic [DW-1:0] rdData,
  output logic          memValid,
  output logic          memWrite,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  input  logic          memReady,
  input  logic [DW-1:0] memRdata,
  output logic          bufEmpty
);
  bufStrobes_t strb;
  logic full, empty, rdHit;

  store_buf_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .rdValid(rdValid),
    .memReady(memReady), .full(full), .empty(empty), .rdHit(rdHit),
    .strb(strb), .wrStall(wrStall), .memValid(memValid),
    .memWrite(memWrite), .rdDone(rdDone)
  );

  store_buf_datapath #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .memRdata(memRdata), .full(full), .empty(empty),
    .rdHit(rdHit), .rdData(rdData), .memAddr(memAddr), .memWdata(memWdata)
  );

  assign bufEmpty = empty;
endmodule

// File: tb/store_drain_buffer_tb.sv
module store_drain_buffer_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrValid = 0, rdValid = 0, memReady = 0;
  logic [31:0] wrAddr = 0, wrData = 0, rdAddr = 0, memRdata = 0;
  logic wrStall, rdDone, memValid, memWrite, bufEmpty;
  logic [31:0] rdData, memAddr, memWdata;

  int checks = 0, errors = 0;
  bit finished = 0;

  // Bench queue model
  logic [31:0] qa [4];
  logic [31:0] qd [4];
  int qn = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  store_drain_buffer u_dut (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr),
    .wrData(wrData), .wrStall(wrStall), .rdValid(rdValid), .rdAddr(rdAddr),
    .rdDone(rdDone), .rdData(rdData), .memValid(memValid),
    .memWrite(memWrite), .memAddr(memAddr), .memWdata(memWdata),
    .memReady(memReady), .memRdata(memRdata), .bufEmpty(bufEmpty)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] step(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  initial begin
    #800000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    chk("R1 empty", 32'(bufEmpty), 1);
    chk("R1 stall", 32'(wrStall), 0);
    chk("R1 memValid", 32'(memValid), 0);

    for (int cyc = 0; cyc < 6000; cyc++) begin
      logic hit, rdMem, pop, push;
      logic [31:0] hitD;
      int phase;
      @(negedge clk);
      lfsr = step(step(step(lfsr)));
      phase = (cyc / 500) % 4;
      // Phases: write-heavy, read-heavy, stalled memory, mixed
      wrValid  = (phase == 1) ? (lfsr[1:0] == 0) : (lfsr[1:0] != 0);
      rdValid  = (phase == 1) ? (lfsr[3:2] != 0) : (lfsr[4:2] == 0);
      memReady = (phase == 2) ? (lfsr[6:4] == 0) : lfsr[5];
      wrAddr   = 32'h100 + 32'({lfsr[8:7]} * 4);
      rdAddr   = lfsr[11] ? 32'h200 : 32'h100 + 32'({lfsr[10:9]} * 4);
      wrData   = 32'(cyc) ^ 32'hA5000000;
      memRdata = {lfsr, ~lfsr};
      #1;
      // expected behaviour from the bench model
      hit = 0; hitD = 0;
      for (int k = 0; k < qn; k++)
        if (qa[k] == rdAddr) begin hit = 1; hitD = qd[k]; end
      rdMem = rdValid && !hit;
      pop   = !rdMem && qn > 0 && memReady;
      push  = wrValid && qn < 4;

      chk("R9 empty", 32'(bufEmpty), 32'(qn == 0));
      chk("R2 stall", 32'(wrStall), 32'(qn == 4));
      chk("R3 memValid", 32'(memValid), 32'(rdMem || qn > 0));
      if (rdMem) begin
        chk("R5 memWrite", 32'(memWrite), 0);
        chk("R5 memAddr", memAddr, rdAddr);
        chk("R5 rdDone", 32'(rdDone), 32'(memReady));
        if (memReady) chk("R5 rdData", rdData, memRdata);
      end else begin
        if (qn > 0) begin
          chk("R3 memWrite", 32'(memWrite), 1);
          chk("R3 R7 memAddr", memAddr, qa[0]);
          chk("R3 R4 memWdata", memWdata, qd[0]);
        end
        if (rdValid) begin
          // R6 R8 R10: hit on entries held at cycle start, port free for drain
          chk("R6 rdDone", 32'(rdDone), 1);
          chk("R6 R8 rdData", rdData, hitD);
        end else begin
          chk("R6 idle rdDone", 32'(rdDone), 0);
        end
      end

      // update model at the edge
      if (pop) begin
        for (int k = 0; k < 3; k++) begin qa[k] = qa[k+1]; qd[k] = qd[k+1]; end
        qn--;
      end
      if (push) begin qa[qn] = wrAddr; qd[qn] = wrData; qn++; end
    end

    // Drain everything with reads off, then confirm empty
    @(negedge clk);
    wrValid = 0; rdValid = 0; memReady = 1;
    repeat (6) @(negedge clk);
    #1;
    chk("R9 drained", 32'(bufEmpty), 1);
    chk("R1 idle port", 32'(memValid), 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule